// File: doc/BRIEF.md
# Register-Launched Pitch Copy Engine

This block moves data between memory regions. Software fills a small bank of 32-bit command slots with a source offset, a destination offset, two pitches, a line length, a line count, a remap setting and a constant. Writing the launch slot then starts one transfer, which takes its parameters from the slots as they stand in that cycle. The launch word itself sets the mode.

The engine has three ways to run. A linear copy moves a run of bytes. A rectangle copy moves a number of lines, each with its own source and destination start that step by separate pitches. A fill writes one 32-bit constant into a run of words. Each word moves through a single request port. A read is issued, its response is collected, and the matching write follows. Launches that ask for tiled layouts, semaphores, interrupts, pipelined transfers or a remap the engine cannot perform are rejected. A rejected launch touches no memory and raises a flag.

Top module: `pitch_copy_engine`

## Requirements
- R1: A command write with index k stores its data in slot k. Slot 0 is the launch slot: a write to it starts a transfer using its own data as the control word and the current contents of the other slots. Writes to any other slot start nothing. The slots are 1 source byte offset, 2 destination byte offset, 3 source pitch, 4 destination pitch, 5 line length, 6 line count, 7 remap setting and 8 fill constant.
- R2: With control bit 0 (rectangle) clear and bit 3 (remap) clear, the engine copies line-length/4 words. Word i is read from source+4i and written to destination+4i.
- R3: With control bit 0 set, the engine copies line-count lines of line-length/4 words each. Line n is read from source + n*source pitch and written to destination + n*destination pitch.
- R4: With bit 3 set, bit 0 clear, remap bits [2:0] equal to 4 (constant selector) and remap bits [17:16] equal to 3 (4-byte element size, stored minus one), the engine writes line-length words, all equal to slot 8. It issues no reads.
- R5: If remap is on together with a selector other than 4, an element size field other than 3, or bit 0 set, the launch is unsupported.
- R6: If control bit 1 (source tiled) or bit 2 (destination tiled) is set, including both at once, the launch is unsupported.
- R7: If control bits [5:4] (semaphore) or [7:6] (interrupt) are non-zero, or bit 8 (pipelined) is set, the launch is unsupported.
- R8: `busy` is high from the cycle after a launch until the last write is accepted. `done` pulses for one cycle in the following cycle, while `busy` is low.
- R9: A launch written while busy is ignored and sets `err_busy`. The next accepted launch clears `err_busy`.
- R10: A zero word count, or a zero line count in rectangle mode, gives `done` one cycle after the launch and issues no request. An unsupported launch behaves the same way and also sets `err_unsup`, which stays set until the next accepted launch.
- R11: A request holds its address, direction and data until `mem_req_ready` accepts it. Read data is taken on `mem_rsp_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_we | input | 1 | Command write strobe |
| cmd_idx | input | IDX_W | Command slot index |
| cmd_data | input | 32 | Command data |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | Request is a write (else read) |
| mem_req_addr | output | ADDR_W | Request byte address |
| mem_req_wdata | output | 32 | Write data |
| mem_rsp_valid | input | 1 | Read response valid |
| mem_rsp_data | input | 32 | Read response data |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| err_unsup | output | 1 | Last accepted launch was unsupported |
| err_busy | output | 1 | A launch arrived while busy |

## Verification
Linear copies are swept over lengths from zero to six words, each with an always-ready port and with a port that stalls three cycles in four. This separates wrong word counts and off-by-one ends from handshake slips. Rectangle copies are swept over line counts zero to three and line lengths one to three words, with unequal source and destination pitches, so that a swapped pitch or a missing line advance shows up in the destination image. Fills of zero to four words confirm that no reads occur. Each reject cause is tried alone, and the bench checks that the memory image stays unchanged. A launch issued while busy must leave the running copy's result intact.

// File: rtl/pce_pkg.sv
package pce_pkg;
  localparam int unsigned NUM_SLOTS   = 9;
  localparam int unsigned SLOT_LAUNCH = 0;
  localparam int unsigned SLOT_SRC    = 1;
  localparam int unsigned SLOT_DST    = 2;
  localparam int unsigned SLOT_SPITCH = 3;
  localparam int unsigned SLOT_DPITCH = 4;
  localparam int unsigned SLOT_LEN    = 5;
  localparam int unsigned SLOT_LINES  = 6;
  localparam int unsigned SLOT_REMAP  = 7;
  localparam int unsigned SLOT_CONST  = 8;

  // control word bit positions
  localparam int unsigned CB_RECT  = 0;
  localparam int unsigned CB_STILE = 1;
  localparam int unsigned CB_DTILE = 2;
  localparam int unsigned CB_REMAP = 3;
  localparam int unsigned CB_PIPE  = 8;

  localparam logic [2:0] SEL_CONST  = 3'd4;
  localparam logic [1:0] ELEM_4BYTE = 2'd3;

  typedef struct packed {
    logic        unsup;
    logic        fill;
    logic [31:0] src;
    logic [31:0] dst;
    logic [31:0] spitch;
    logic [31:0] dpitch;
    logic [31:0] words;
    logic [31:0] lines;
    logic [31:0] fill_val;
  } job_t;
endpackage

// File: rtl/pce_regs.sv
module pce_regs #(
  parameter int unsigned NSLOT = 9,
  parameter int unsigned IDX_W = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic [IDX_W-1:0]        idx,
  input  logic [31:0]             data,
  output logic [NSLOT-1:0][31:0]  bank
);
  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    always_ff @(posedge clk) begin
      if (rst)                          bank[g] <= '0;
      else if (we && idx == IDX_W'(g))  bank[g] <= data;
    end
  end
endmodule

// File: rtl/pce_decode.sv
module pce_decode
  import pce_pkg::*;
(
  input  logic [31:0] ctrl,
  input  logic [31:0] src,
  input  logic [31:0] dst,
  input  logic [31:0] spitch,
  input  logic [31:0] dpitch,
  input  logic [31:0] len,
  input  logic [31:0] lines,
  input  logic [31:0] remap,
  input  logic [31:0] cval,
  output job_t        job
);
  logic rect, tiled, side_ops, remap_on, remap_ok;
  logic unused_bits;

  assign rect     = ctrl[CB_RECT];
  assign tiled    = ctrl[CB_STILE] | ctrl[CB_DTILE];
  assign side_ops = (ctrl[5:4] != 2'd0) | (ctrl[7:6] != 2'd0) | ctrl[CB_PIPE];
  assign remap_on = ctrl[CB_REMAP];
  assign remap_ok = !rect && remap[2:0] == SEL_CONST && remap[17:16] == ELEM_4BYTE;

  always_comb begin
    job.unsup    = tiled | side_ops | (remap_on & !remap_ok);
    job.fill     = remap_on;
    job.src      = src;
    job.dst      = dst;
    job.spitch   = spitch;
    job.dpitch   = dpitch;
    job.words    = remap_on ? len : {2'b00, len[31:2]};
    job.lines    = rect ? lines : 32'd1;
    job.fill_val = cval;
  end

  assign unused_bits = ^{ctrl[31:9], remap[31:18], remap[15:3]};
endmodule

// File: rtl/pce_seq.sv
module pce_seq
  import pce_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  job_t              job,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              busy,
  output logic              done
);
  typedef enum logic [1:0] {S_IDLE, S_RD, S_WAIT, S_WR} st_e;

  st_e               st;
  logic              fill_q, done_q;
  logic [ADDR_W-1:0] src_line, dst_line, sp, dp, off;
  logic [CNT_W-1:0]  wcnt, lcnt, wlast, llast;
  logic [CNT_W-1:0]  words_t, lines_t;
  logic [31:0]       data_q;
  logic              empty, last_w, last_l, unused_job;

  assign words_t = job.words[CNT_W-1:0];
  assign lines_t = job.lines[CNT_W-1:0];
  assign empty   = job.unsup || words_t == '0 || lines_t == '0;
  assign last_w  = wcnt == wlast;
  assign last_l  = lcnt == llast;
  assign unused_job = ^{job.words, job.lines, job.src, job.dst, job.spitch, job.dpitch};

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= S_IDLE;
      done_q   <= 1'b0;
      fill_q   <= 1'b0;
      src_line <= '0;
      dst_line <= '0;
      sp       <= '0;
      dp       <= '0;
      off      <= '0;
      wcnt     <= '0;
      lcnt     <= '0;
      wlast    <= '0;
      llast    <= '0;
      data_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          fill_q   <= job.fill;
          src_line <= job.src[ADDR_W-1:0];
          dst_line <= job.dst[ADDR_W-1:0];
          sp       <= job.spitch[ADDR_W-1:0];
          dp       <= job.dpitch[ADDR_W-1:0];
          off      <= '0;
          wcnt     <= '0;
          lcnt     <= '0;
          wlast    <= words_t - 1'b1;
          llast    <= lines_t - 1'b1;
          data_q   <= job.fill_val;
          if (empty)         done_q <= 1'b1;
          else if (job.fill) st <= S_WR;
          else               st <= S_RD;
        end
        S_RD:   if (mem_req_ready) st <= S_WAIT;
        S_WAIT: if (mem_rsp_valid) begin
          data_q <= mem_rsp_data;
          st     <= S_WR;
        end
        S_WR: if (mem_req_ready) begin
          if (last_w && last_l) begin
            st     <= S_IDLE;
            done_q <= 1'b1;
          end else begin
            st <= fill_q ? S_WR : S_RD;
            if (last_w) begin
              wcnt     <= '0;
              off      <= '0;
              lcnt     <= lcnt + 1'b1;
              src_line <= src_line + sp;
              dst_line <= dst_line + dp;
            end else begin
              wcnt <= wcnt + 1'b1;
              off  <= off + ADDR_W'(4);
            end
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mem_req_valid = (st == S_RD) || (st == S_WR);
  assign mem_req_write = (st == S_WR);
  assign mem_req_addr  = ((st == S_WR) ? dst_line : src_line) + off;
  assign mem_req_wdata = data_q;
  assign busy          = (st != S_IDLE);
  assign done          = done_q;

  // R11: a stalled request keeps its contents
  a_r11_req_hold: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr)
      && $stable(mem_req_write) && $stable(mem_req_wdata));
  // R8: busy ends only with a done pulse
  a_r8_busy_end: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> done);
endmodule

// File: rtl/pitch_copy_engine.sv
module pitch_copy_engine
  import pce_pkg::*;
#(
  parameter int unsigned IDX_W  = 4,
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_we,
  input  logic [IDX_W-1:0]  cmd_idx,
  input  logic [31:0]       cmd_data,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_data,
  output logic              busy,
  output logic              done,
  output logic              err_unsup,
  output logic              err_busy
);
  logic [NUM_SLOTS-1:0][31:0] bank;
  job_t job;
  logic launch_hit, accept;

  pce_regs #(.NSLOT(NUM_SLOTS), .IDX_W(IDX_W)) u_regs (
    .clk(clk), .rst(rst), .we(cmd_we), .idx(cmd_idx), .data(cmd_data), .bank(bank));

  pce_decode u_dec (
    .ctrl(cmd_data), .src(bank[SLOT_SRC]), .dst(bank[SLOT_DST]),
    .spitch(bank[SLOT_SPITCH]), .dpitch(bank[SLOT_DPITCH]), .len(bank[SLOT_LEN]),
    .lines(bank[SLOT_LINES]), .remap(bank[SLOT_REMAP]), .cval(bank[SLOT_CONST]),
    .job(job));

  assign launch_hit = cmd_we && cmd_idx == IDX_W'(SLOT_LAUNCH);
  assign accept     = launch_hit && !busy;

  pce_seq #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(accept), .job(job),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done));

  always_ff @(posedge clk) begin
    if (rst) begin
      err_unsup <= 1'b0;
      err_busy  <= 1'b0;
    end else if (accept) begin
      err_unsup <= job.unsup;
      err_busy  <= 1'b0;
    end else if (launch_hit) begin
      err_busy  <= 1'b1;
    end
  end

  // R9: launch while busy is flagged
  a_r9_busy_launch: assert property (@(posedge clk) disable iff (rst)
    launch_hit && busy |=> err_busy);
  // R5, R6, R7: rejected launch finishes at once without memory traffic
  a_r5_reject_quiet: assert property (@(posedge clk) disable iff (rst)
    accept && job.unsup |=> !mem_req_valid && !busy && done && err_unsup);
  // R8: done is never high while busy
  a_r8_done_idle: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);
endmodule

// File: tb/test_pitch_copy_engine.sv
`timescale 1ns/1ps
module test_pitch_copy_engine;
  localparam int IDX_W = 4;
  localparam int ADDR_W = 32;

  logic clk = 1'b0;
  logic rst;
  always #2.5 clk = ~clk;

  logic              cmd_we;
  logic [IDX_W-1:0]  cmd_idx;
  logic [31:0]       cmd_data;
  logic              mem_req_valid, mem_req_ready, mem_req_write;
  logic [ADDR_W-1:0] mem_req_addr;
  logic [31:0]       mem_req_wdata;
  logic              mem_rsp_valid = 1'b0;
  logic [31:0]       mem_rsp_data = '0;
  logic              busy, done, err_unsup, err_busy;

  pitch_copy_engine #(.IDX_W(IDX_W), .ADDR_W(ADDR_W), .CNT_W(16)) i_pitch_copy_engine (
    .clk(clk), .rst(rst), .cmd_we(cmd_we), .cmd_idx(cmd_idx), .cmd_data(cmd_data),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .busy(busy), .done(done),
    .err_unsup(err_unsup), .err_busy(err_busy));

  int checks = 0;
  int errors = 0;
  logic [31:0] mem [256];
  logic [31:0] refm [256];
  logic        init_req = 1'b0;
  logic [7:0]  seed = '0;
  logic        slow = 1'b0;
  logic [3:0]  rcnt = '0;
  int          req_cnt = 0;

  assign mem_req_ready = slow ? (rcnt[1:0] == 2'd3) : 1'b1;

  function automatic logic [31:0] pat(input int i, input logic [7:0] s);
    return {s, 8'h5A, 8'(i), 8'(i * 7 + 3)};
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    rcnt <= rcnt + 1'b1;
    mem_rsp_valid <= 1'b0;
    if (init_req) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i, seed);
      req_cnt <= 0;
    end else if (mem_req_valid && mem_req_ready) begin
      req_cnt <= req_cnt + 1;
      if (mem_req_write) mem[mem_req_addr[9:2]] <= mem_req_wdata;
      else begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_data  <= mem[mem_req_addr[9:2]];
      end
    end
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic init_mem(input logic [7:0] s);
    seed = s;
    for (int i = 0; i < 256; i++) refm[i] = pat(i, s);
    @(negedge clk) init_req = 1'b1;
    @(negedge clk) init_req = 1'b0;
  endtask

  task automatic mth(input int idx, input logic [31:0] d);
    @(negedge clk);
    cmd_we = 1'b1; cmd_idx = IDX_W'(idx); cmd_data = d;
    @(negedge clk);
    cmd_we = 1'b0;
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!done && n < 4000) begin @(negedge clk); n++; end
    chk(req, "done seen", 32'(done), 32'd1);
  endtask

  task automatic cmp_mem(input string req);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    chk(req, "memory mismatches", 32'(bad), 32'd0);
  endtask

  task automatic setup(input logic [31:0] src, dst, sp, dp, len, lines);
    mth(1, src); mth(2, dst); mth(3, sp); mth(4, dp); mth(5, len); mth(6, lines);
  endtask

  task automatic reject(input string req, input logic [31:0] ctrl, input logic [31:0] remap);
    init_mem(8'h77);
    setup(32'h40, 32'h200, 32'd16, 32'd16, 32'd8, 32'd2);
    mth(7, remap); mth(8, 32'h12345678);
    mth(0, ctrl);
    chk(req, "done right after launch", 32'(done), 32'd1);
    chk(req, "err_unsup", 32'(err_unsup), 32'd1);
    chk(req, "busy", 32'(busy), 32'd0);
    @(negedge clk);
    chk(req, "request count", 32'(req_cnt), 32'd0);
    cmp_mem(req);
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst = 1'b1; cmd_we = 1'b0; cmd_idx = '0; cmd_data = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R8", "reset busy", 32'(busy), 32'd0);
    chk("R8", "reset done", 32'(done), 32'd0);
    chk("R10", "reset err_unsup", 32'(err_unsup), 32'd0);
    chk("R9", "reset err_busy", 32'(err_busy), 32'd0);
    chk("R11", "reset req valid", 32'(mem_req_valid), 32'd0);

    // R1: non-launch slot writes start nothing
    init_mem(8'h01);
    mth(1, 32'h40); mth(5, 32'd16);
    chk("R1", "busy after slot write", 32'(busy), 32'd0);
    @(negedge clk);
    chk("R1", "no requests", 32'(req_cnt), 32'd0);
    chk("R1", "no done", 32'(done), 32'd0);

    // R2 / R11 linear copy sweep
    for (int s = 0; s < 2; s++) begin
      for (int nw = 0; nw <= 6; nw++) begin
        slow = (s == 1);
        init_mem(8'(16 + nw + 8 * s));
        setup(32'h40 + 32'(4 * nw), 32'h200, 32'd0, 32'd0, 32'(4 * nw), 32'd9);
        mth(0, 32'h0);
        wait_done(s == 1 ? "R11" : "R2");
        for (int w = 0; w < nw; w++) refm[128 + w] = refm[16 + nw + w];
        chk("R8", "busy low at done", 32'(busy), 32'd0);
        cmp_mem(s == 1 ? "R11" : "R2");
        chk(nw == 0 ? "R10" : "R2", "request count", 32'(req_cnt), 32'(2 * nw));
        chk("R2", "err_unsup", 32'(err_unsup), 32'd0);
        @(negedge clk);
        chk("R8", "done single cycle", 32'(done), 32'd0);
      end
    end

    // R3 rectangle sweep
    for (int nl = 0; nl <= 3; nl++) begin
      for (int nw = 1; nw <= 3; nw++) begin
        slow = ((nl + nw) % 2 == 1);
        init_mem(8'(64 + nl * 4 + nw));
        setup(32'h20, 32'h240, 32'd20, 32'd28, 32'(4 * nw), 32'(nl));
        mth(0, 32'h1);
        wait_done("R3");
        for (int l = 0; l < nl; l++)
          for (int w = 0; w < nw; w++)
            refm[(32'h240 + 28 * l) / 4 + w] = refm[(32'h20 + 20 * l) / 4 + w];
        cmp_mem("R3");
        chk(nl == 0 ? "R10" : "R3", "request count", 32'(req_cnt), 32'(2 * nw * nl));
      end
    end

    // R10: zero length in rectangle mode
    slow = 1'b0;
    init_mem(8'h90);
    setup(32'h20, 32'h240, 32'd20, 32'd28, 32'd0, 32'd3);
    mth(0, 32'h1);
    chk("R10", "immediate done", 32'(done), 32'd1);
    @(negedge clk);
    chk("R10", "zero-length requests", 32'(req_cnt), 32'd0);

    // R4 fill sweep
    for (int nw = 0; nw <= 4; nw++) begin
      slow = (nw % 2 == 1);
      init_mem(8'(160 + nw));
      setup(32'h40, 32'h204, 32'd0, 32'd0, 32'(nw), 32'd5);
      mth(7, 32'h0003_0004); mth(8, 32'hCAFE_F00D);
      mth(0, 32'h8);
      wait_done("R4");
      for (int w = 0; w < nw; w++) refm[129 + w] = 32'hCAFE_F00D;
      cmp_mem("R4");
      chk(nw == 0 ? "R10" : "R4", "write-only count", 32'(req_cnt), 32'(nw));
      chk("R4", "err_unsup", 32'(err_unsup), 32'd0);
    end
    slow = 1'b0;

    reject("R5", 32'h8, 32'h0002_0004);   // element size not 4 bytes
    reject("R5", 32'h8, 32'h0003_0001);   // non-constant selector
    reject("R5", 32'h9, 32'h0003_0004);   // remap in rectangle mode
    reject("R6", 32'h6, 32'h0);           // both tiled
    reject("R6", 32'h3, 32'h0);           // source tiled
    reject("R7", 32'h10, 32'h0);          // semaphore
    reject("R7", 32'h40, 32'h0);          // interrupt
    reject("R7", 32'h100, 32'h0);         // pipelined

    // R9: launch while busy
    slow = 1'b1;
    init_mem(8'hB0);
    setup(32'h40, 32'h200, 32'd0, 32'd0, 32'd32, 32'd1);
    mth(7, 32'h0003_0004); mth(8, 32'hDEAD_BEEF);
    mth(0, 32'h0);
    chk("R8", "busy after launch", 32'(busy), 32'd1);
    mth(0, 32'h8);
    chk("R9", "err_busy set", 32'(err_busy), 32'd1);
    wait_done("R9");
    for (int w = 0; w < 8; w++) refm[128 + w] = refm[16 + w];
    cmp_mem("R9");
    chk("R9", "request count", 32'(req_cnt), 32'd16);
    @(negedge clk);
    chk("R9", "no second transfer", 32'(busy), 32'd0);
    mth(5, 32'd4);
    mth(0, 32'h0);
    chk("R9", "err_busy cleared", 32'(err_busy), 32'd0);
    wait_done("R9");
    slow = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule